// File: doc/BRIEF.md
# Soft Mute and Digital Attenuator

This block scales a stereo stream of 20-bit signed audio samples by a programmable linear gain. A 7-bit attenuation code k selects a gain of (127 − k)/127, so code 0 passes samples unchanged and code 127 silences the output completely. The level in decibels is therefore 20·log10(1 − k/127).

The gain actually applied is held in an internal effective code. On each sample strobe this code moves one step toward a target. The target is 127 while mute is requested and the programmed attenuation code otherwise. A mute request therefore fades the signal to silence over 127 sample periods instead of cutting it at once. Releasing the mute, or changing the code, ramps the gain in the same single-step way. Both channels are scaled by the same effective code on the same strobe. The scaled pair leaves through a register together with an output strobe.

Top module: `soft_mute_atten`

## Requirements
- R1: After reset the effective code is 0 (no attenuation, mute off), out_valid is 0 and both outputs are 0, so the first sample after reset passes unchanged.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. Without a strobe, out_left and out_right hold their previous values.
- R3: For each strobe, each output equals the input multiplied by (127 − k)/127 and truncated toward zero, where k is the effective code before that strobe's step. For example, −1 at k = 1 gives 0.
- R4: When the effective code is 127, both outputs are exactly 0 for any input.
- R5: The effective code changes only on a strobe, and by exactly one step toward the target. It stays unchanged when it already equals the target. Without mute, the target is atten_code.
- R6: With mute_req high, the target is 127. Starting from code 0, strobes number 0 to 126 are scaled with codes 0 to 126, and strobe 127 and later give silence.
- R7: After mute_req falls, the code ramps back down toward atten_code by one per strobe.
- R8: Both channels use the same effective code on the same strobe, so equal inputs give equal outputs.
- R9: Outputs stay within the 20-bit signed range, and their magnitude never exceeds the input's. A non-negative input never gives a negative output, and −524288 at code 0 gives −524288.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample pair |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| atten_code | input | 7 | Programmed attenuation code, 0 to 127 |
| mute_req | input | 1 | Soft mute request, high to fade to silence |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
The bench goes after the edges of the mute ramp. At strobe 126 a full-scale sample must still come out as 4128, and at strobe 127 it must be exactly zero. A design that reaches silence one strobe early or late, or that cuts the gain at once, misses one of these values. Negative inputs at small gains catch a design that rounds toward minus infinity, because it yields −1 where 0 is expected. The bench also holds back strobes while the code or mute changes. A design that steps the gain on the clock rather than on the strobe then shows a different scale on the next sample. Long random runs mix mute toggles and code changes, so that a wrong step direction or a step larger than one drifts away from the bench's model.

// File: rtl/soft_mute_atten.sv
module soft_mute_atten #(
  parameter int DATA_W = 20,
  parameter int CODE_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic        [CODE_W-1:0] atten_code,
  input  logic                     mute_req,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);

  localparam int FULL   = (1 << CODE_W) - 1;
  localparam int PROD_W = DATA_W + CODE_W;
  localparam logic [CODE_W-1:0] FULL_C   = CODE_W'(FULL);
  localparam logic [CODE_W:0]   DIVISOR  = (CODE_W+1)'(FULL);
  localparam logic [PROD_W-1:0] POS_LIM  = PROD_W'((64'd1 << (DATA_W-1)) - 64'd1);
  localparam logic [PROD_W-1:0] NEG_LIM  = PROD_W'(64'd1 << (DATA_W-1));

  logic [CODE_W-1:0] eff_code;
  logic [CODE_W-1:0] tgt_code;
  logic [CODE_W-1:0] gain;
  logic signed [DATA_W-1:0] scaled_l;
  logic signed [DATA_W-1:0] scaled_r;

  assign tgt_code = mute_req ? FULL_C : atten_code;
  assign gain     = FULL_C - eff_code;

  function automatic logic signed [DATA_W-1:0] apply_gain(
    input logic signed [DATA_W-1:0] s,
    input logic        [CODE_W-1:0] g
  );
    logic [DATA_W-1:0] mag;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    logic [CODE_W:0]   rem;
    logic [DATA_W-1:0] res;
    mag  = s[DATA_W-1] ? (~s) + DATA_W'(1) : s;
    prod = PROD_W'(mag) * PROD_W'(g);
    rem  = '0;
    quo  = '0;
    for (int i = PROD_W - 1; i >= 0; i--) begin
      rem = {rem[CODE_W-1:0], prod[i]};
      if (rem >= DIVISOR) begin
        rem    = rem - DIVISOR;
        quo[i] = 1'b1;
      end
    end
    if (s[DATA_W-1]) begin
      if (quo > NEG_LIM) quo = NEG_LIM;
      res = DATA_W'(~quo + PROD_W'(1));
    end else begin
      if (quo > POS_LIM) quo = POS_LIM;
      res = DATA_W'(quo);
    end
    return res;
  endfunction

  assign scaled_l = apply_gain(in_left, gain);
  assign scaled_r = apply_gain(in_right, gain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_code  <= '0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= scaled_l;
        out_right <= scaled_r;
        if (eff_code < tgt_code)
          eff_code <= eff_code + CODE_W'(1);
        else if (eff_code > tgt_code)
          eff_code <= eff_code - CODE_W'(1);
      end
    end
  end

endmodule

module soft_mute_atten_chk #(
  parameter int DATA_W = 20,
  parameter int CODE_W = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     mute_req,
  input logic        [CODE_W-1:0] eff,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right
);
  localparam logic [CODE_W-1:0] FULL_C = CODE_W'((1 << CODE_W) - 1);

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  hold_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_left) && $stable(out_right)));
  // R5
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(eff));
  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (eff == $past(eff)) || (eff == $past(eff) + CODE_W'(1)) ||
                 (eff == $past(eff) - CODE_W'(1)));
  // R6
  mute_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mute_req && eff != FULL_C) |=> eff == $past(eff) + CODE_W'(1));
  // R4
  silent_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff == FULL_C) |=> (out_left == '0 && out_right == '0));
  // R9
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_left[DATA_W-1]) |=> !out_left[DATA_W-1]);
  // R8
  channel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_left == in_right) |=> out_left == out_right);
endmodule

bind soft_mute_atten soft_mute_atten_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
  .in_right(in_right), .mute_req(mute_req), .eff(eff_code),
  .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

// File: tb/test_soft_mute_atten.sv
`timescale 1ns/1ps
module test_soft_mute_atten;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [19:0] in_left = '0;
  logic signed [19:0] in_right = '0;
  logic [6:0] atten_code = '0;
  logic mute_req = 1'b0;
  logic out_valid;
  logic signed [19:0] out_left;
  logic signed [19:0] out_right;

  int checks = 0;
  int errors = 0;
  int model_k = 0;
  bit done = 1'b0;

  soft_mute_atten i_soft_mute_atten (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .atten_code(atten_code), .mute_req(mute_req),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  always #10 clk = ~clk;

  function automatic longint expect_scale(longint s, int k);
    longint m;
    m = (s < 0) ? -s : s;
    m = (m * (127 - k)) / 127;
    return (s < 0) ? -m : m;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(string tag, longint l, longint r);
    int tgt;
    string t;
    @(negedge clk);
    in_left  = l[19:0];
    in_right = r[19:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    t = (model_k == 127) ? {tag, "/R4"} : tag;
    chk({t, " valid"}, longint'(out_valid), 1);
    chk({t, " left"}, longint'(out_left), expect_scale(l, model_k));
    chk({t, " right"}, longint'(out_right), expect_scale(r, model_k));
    tgt = mute_req ? 127 : int'(atten_code);
    if (model_k < tgt) model_k++;
    else if (model_k > tgt) model_k--;
  endtask

  function automatic longint rnd_sample();
    return longint'($signed(20'($urandom)));
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic signed [19:0] held_l, held_r;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R1 valid", longint'(out_valid), 0);
    chk("R1 left", longint'(out_left), 0);
    chk("R1 right", longint'(out_right), 0);
    rst_n = 1'b1;

    send("R1/R9 extremes", 524287, -524288);
    send("R8 equal", 1000, 1000);
    send("R9 small", -1, 1);

    atten_code = 7'd5;
    for (int i = 0; i < 6; i++) send("R5 ramp", rnd_sample(), rnd_sample());
    chk("R5 code reached", model_k, 5);

    atten_code = 7'd20;
    held_l = out_left;
    held_r = out_right;
    repeat (10) begin
      @(negedge clk);
      chk("R2 idle valid", longint'(out_valid), 0);
    end
    chk("R2 held left", longint'(out_left), longint'(held_l));
    chk("R2 held right", longint'(out_right), longint'(held_r));
    send("R5 no step while idle", 524287, -524287);

    atten_code = 7'd0;
    while (model_k != 0) send("R5 ramp down", rnd_sample(), rnd_sample());

    mute_req = 1'b1;
    for (int n = 0; n < 127; n++) send("R6 fade", 524287, -524288);
    chk("R6 at 126 left", longint'(out_left), 4128);
    send("R6 silence", 524287, -524288);
    chk("R6 silent left", longint'(out_left), 0);
    chk("R6 silent right", longint'(out_right), 0);
    send("R4 small", -126, 126);
    send("R4 held mute", rnd_sample(), rnd_sample());

    mute_req = 1'b0;
    atten_code = 7'd40;
    for (int n = 0; n < 87; n++) send("R7 release", 524287, -3);
    send("R7 settled", 524287, 524287);
    chk("R7 settled value", longint'(out_left), 524287 * 87 / 127);

    atten_code = 7'd126;
    while (model_k != 126) send("R3 ramp", rnd_sample(), rnd_sample());
    send("R3 trunc neg", -1, -127);
    send("R3 trunc pos", 126, 127);

    for (int i = 0; i < 3000; i++) begin
      longint a;
      if (($urandom % 50) == 0) atten_code = 7'($urandom);
      if (($urandom % 200) == 0) mute_req = ~mute_req;
      if (($urandom % 10) == 0) repeat ($urandom % 4) @(negedge clk);
      a = rnd_sample();
      if (($urandom % 8) == 0) send("R8 random equal", a, a);
      else send("R3 random", a, rnd_sample());
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule